// File: doc/BRIEF.md
# Programmable Read Latency Pipeline

This block sits on the read path of a memory controller or memory model. It turns each read command into a delayed data beat. When a command is sampled, the read word is captured and carried down a short register chain. It comes out after a selectable number of clock cycles, together with a valid flag. A bus-drive enable opens one cycle before the first beat. It stays open across runs of consecutive beats and closes in the cycle after the last beat.

The latency is set by a two-bit code. A new code is taken only while nothing is in flight. A request made while reads are still moving through the chain is refused and flagged, so the beats already in flight keep the timing they were issued with. The all-zero code is reserved: while it is applied, the block refuses commands, keeps its outputs silent and raises an error flag.

Top module: `rd_lat_pipe`

## Requirements
- R1: The latency code maps 2'b01 to one cycle, 2'b10 to two cycles and 2'b11 to three cycles. After reset the active latency is two cycles (code 2'b10).
- R2: A command sampled at rising edge r makes `q_valid` high, with `q_data` equal to the word sampled with the command, for exactly the one cycle that begins after edge r+L-1, where L is the active latency.
- R3: `drv_en` is high in the cycle before each valid beat. At latency one, this is the same cycle in which `rd_cmd` is presented.
- R4: Commands on consecutive cycles give valid beats on consecutive cycles with no gap, and `drv_en` stays high throughout.
- R5: `drv_en` is low in the cycle after the last valid beat, unless a new lead cycle falls there.
- R6: `q_data` is all zeros whenever `q_valid` is low.
- R7: While `lat_sel` is 2'b00, `cfg_err` is high, commands are discarded, `q_valid` and `drv_en` are held low, and the active latency is unchanged.
- R8: A new non-reserved code is adopted only when every stage is empty and `rd_cmd` is low. Otherwise the request is ignored and `chg_rej` is high for the cycle after the refused edge.
- R9: Reset clears every stage, `q_valid`, `drv_en` and `chg_rej`. A read in flight when reset is applied never appears at the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_cmd | input | 1 | Read command, one beat per cycle |
| rd_data | input | DATA_W | Read word captured with the command |
| lat_sel | input | 2 | Requested latency code |
| q_data | output | DATA_W | Delayed read word, zero when not valid |
| q_valid | output | 1 | Delayed beat is valid |
| drv_en | output | 1 | Bus drive enable, leads valid by one cycle |
| cfg_err | output | 1 | Reserved latency code is applied |
| chg_rej | output | 1 | Latency change was refused at the previous edge |

## Verification
A stage bit that is lost or stuck shows up within three cycles of the command. The beat arrives early, arrives late, or is missing at `q_valid`. A wrong lead tap shows as `drv_en` rising in the valid cycle rather than the cycle before it. It can also show as a one-cycle hole in `drv_en` between two adjacent bursts. A latency register that accepts a change while busy moves the in-flight beat, and the beat lands a cycle away from where the command placed it. A missing refusal shows as `chg_rej` staying low on the edge after the request.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;
   localparam int LAT_W = 2;
   localparam int NSTG  = (1 << LAT_W) - 1;

   typedef enum logic [LAT_W-1:0] {
      LAT_RSVD  = 2'b00,
      LAT_ONE   = 2'b01,
      LAT_TWO   = 2'b10,
      LAT_THREE = 2'b11
   } lat_code_t;

   function automatic logic code_reserved(input logic [LAT_W-1:0] c);
      return c == LAT_RSVD;
   endfunction
endpackage

// File: rtl/rdlat_cfg.sv
module rdlat_cfg
   import rdlat_pkg::*;
#(
   parameter lat_code_t RST_LAT = LAT_TWO
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LAT_W-1:0] lat_sel,
   input  logic             rd_cmd,
   input  logic             pipe_empty,
   output lat_code_t        lat_q,
   output logic             cfg_err,
   output logic             chg_rej,
   output logic             entry
);
   logic rsvd, want, take;

   if (RST_LAT == LAT_RSVD) begin : g_bad_rst
      $error("RST_LAT must not be the reserved code");
   end

   always_comb begin
      rsvd  = code_reserved(lat_sel);
      want  = !rsvd && (lat_sel != lat_q);
      take  = want && pipe_empty && !rd_cmd;
      entry = rd_cmd && !rsvd;
   end

   assign cfg_err = rsvd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q   <= RST_LAT;
         chg_rej <= 1'b0;
      end else begin
         if (take) lat_q <= lat_code_t'(lat_sel);
         chg_rej <= want && !take;
      end
   end

   AST_LAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      lat_q != LAT_RSVD); // R1
   AST_LAT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q != $past(lat_q)) |-> $past(pipe_empty && !rd_cmd)); // R8
   AST_REJ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      chg_rej |-> (lat_q == $past(lat_q))); // R8
endmodule

// File: rtl/rdlat_stages.sv
module rdlat_stages #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_vld,
   input  logic [DATA_W-1:0]             in_data,
   output logic [DEPTH-1:0]              vld,
   output logic [DEPTH-1:0][DATA_W-1:0]  dat,
   output logic                          empty
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least one");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least one");
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_stg
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld[0] <= 1'b0;
               dat[0] <= '0;
            end else begin
               vld[0] <= in_vld;
               dat[0] <= in_vld ? in_data : '0;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld[k] <= 1'b0;
               dat[k] <= '0;
            end else begin
               vld[k] <= vld[k-1];
               dat[k] <= dat[k-1];
            end
         end
         AST_STAGE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
            vld[k-1] |=> vld[k]); // R2
      end
   end

   assign empty = ~|vld;
endmodule

// File: rtl/rdlat_tap.sv
module rdlat_tap
   import rdlat_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  lat_code_t                    lat,
   input  logic [NSTG-1:0]              vld,
   input  logic [NSTG-1:0][DATA_W-1:0]  dat,
   input  logic                         entry,
   input  logic                         quiet,
   output logic                         q_valid,
   output logic [DATA_W-1:0]            q_data,
   output logic                         drv_en
);
   logic             vsel, lead;
   logic [DATA_W-1:0] dsel;

   always_comb begin
      vsel = 1'b0;
      dsel = '0;
      lead = (lat == LAT_ONE) ? entry : 1'b0;
      for (int k = 0; k < NSTG; k++) begin
         if (int'(lat) == k + 1) begin
            vsel = vld[k];
            dsel = dat[k];
         end
         if (int'(lat) == k + 2) lead = vld[k];
      end
      q_valid = vsel && !quiet;
      q_data  = q_valid ? dsel : '0;
      drv_en  = (lead || vsel) && !quiet;
   end
endmodule

// File: rtl/rd_lat_pipe.sv
module rd_lat_pipe
   import rdlat_pkg::*;
#(
   parameter int        DATA_W  = 16,
   parameter lat_code_t RST_LAT = LAT_TWO
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_cmd,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [1:0]        lat_sel,
   output logic [DATA_W-1:0] q_data,
   output logic              q_valid,
   output logic              drv_en,
   output logic              cfg_err,
   output logic              chg_rej
);
   lat_code_t                   lat_q;
   logic                        entry, empty;
   logic [NSTG-1:0]             vld;
   logic [NSTG-1:0][DATA_W-1:0] dat;

   rdlat_cfg #(.RST_LAT(RST_LAT)) u_cfg (
      .clk(clk), .rst_n(rst_n), .lat_sel(lat_sel), .rd_cmd(rd_cmd),
      .pipe_empty(empty), .lat_q(lat_q), .cfg_err(cfg_err),
      .chg_rej(chg_rej), .entry(entry)
   );

   rdlat_stages #(.DATA_W(DATA_W), .DEPTH(NSTG)) u_stg (
      .clk(clk), .rst_n(rst_n), .in_vld(entry), .in_data(rd_data),
      .vld(vld), .dat(dat), .empty(empty)
   );

   rdlat_tap #(.DATA_W(DATA_W)) u_tap (
      .lat(lat_q), .vld(vld), .dat(dat), .entry(entry), .quiet(cfg_err),
      .q_valid(q_valid), .q_data(q_data), .drv_en(drv_en)
   );

   AST_DRV_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> drv_en); // R3
   AST_DRV_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(q_valid) && !$past(cfg_err)) |-> $past(drv_en)); // R3
   AST_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |-> (q_data == '0)); // R6
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!q_valid && !drv_en)); // R7
endmodule

// File: tb/rd_lat_pipe_bench.sv
module rd_lat_pipe_bench;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_cmd = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic [1:0]    lat_sel = 2'b10;
   logic [DW-1:0] q_data;
   logic          q_valid, drv_en, cfg_err, chg_rej;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   rd_lat_pipe #(.DATA_W(DW)) u_rd_lat_pipe (
      .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_data(rd_data),
      .lat_sel(lat_sel), .q_data(q_data), .q_valid(q_valid),
      .drv_en(drv_en), .cfg_err(cfg_err), .chg_rej(chg_rej)
   );

   task automatic check(input string req, input string what,
                        input logic [DW+1:0] act, input logic [DW+1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Drives an 8-cycle command pattern and compares every cycle against
   // the timing of R2/R3/R5/R6 for latency q.
   task automatic run_pattern(input int q, input logic [7:0] pat,
                              input logic [DW-1:0] base, input string req);
      for (int t = 0; t < 8 + q + 2; t++) begin
         logic ev, ed;
         logic [DW-1:0] edat;
         @(negedge clk);
         rd_cmd  = (t < 8) ? pat[t] : 1'b0;
         rd_data = base + DW'(t);
         #1;
         ev   = (t - q >= 0) && (t - q < 8) && pat[t-q];
         ed   = ev || ((t - q + 1 >= 0) && (t - q + 1 < 8) && pat[t-q+1]);
         edat = ev ? base + DW'(t - q) : '0;
         check(req, $sformatf("t%0d {valid,drv,data}", t),
               {ev ? 1'b1 : 1'b0, drv_en ? 1'b1 : 1'b0, q_data} & '0 |
               {q_valid, drv_en, q_data}, {ev, ed, edat});
      end
      rd_cmd = 1'b0;
   endtask

   task automatic t_reset_state();
      #1;
      check("R9", "outputs in reset", {q_valid, drv_en, q_data}, '0);
      check("R9", "chg_rej in reset", {{DW+1{1'b0}}, chg_rej}, '0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_default_latency();
      // R1: reset latency is two cycles
      run_pattern(2, 8'b0000_0001, 16'h1000, "R1");
      run_pattern(2, 8'b0010_0101, 16'h1100, "R2");
   endtask

   task automatic t_set_latency(input logic [1:0] code, input int q);
      @(negedge clk);
      lat_sel = code;
      @(negedge clk);
      #1;
      check("R8", "idle change accepted", {{DW+1{1'b0}}, chg_rej}, '0);
      run_pattern(q, 8'b0000_0001, 16'h2000 + DW'(q), "R1");
   endtask

   task automatic t_lat1_lead();
      // R3: at latency one drv_en rises with the command itself
      run_pattern(1, 8'b0100_1001, 16'h3000, "R3");
   endtask

   task automatic t_back_to_back(input int q);
      // R4: consecutive commands, no gap in valid or drive
      run_pattern(q, 8'b0011_1111, 16'h4000 + DW'(q << 8), "R4");
   endtask

   task automatic t_tail(input int q);
      // R5: separated beats, drive drops after each last beat
      run_pattern(q, 8'b1000_1011, 16'h5000 + DW'(q << 8), "R5");
      // R6: zero data on idle cycles is part of every pattern compare
      run_pattern(q, 8'b0001_0000, 16'h5A00, "R6");
   endtask

   task automatic t_busy_change();
      // latency 2 active: command at t0, change request at t1
      @(negedge clk);
      rd_cmd = 1'b1; rd_data = 16'hBEEF;
      @(negedge clk);
      rd_cmd = 1'b0; lat_sel = 2'b11;
      @(negedge clk);
      lat_sel = 2'b10;
      #1;
      check("R8", "chg_rej after busy request", {{DW+1{1'b0}}, chg_rej}, 1);
      check("R8", "beat keeps old timing", {q_valid, drv_en, q_data},
            {1'b1, 1'b1, 16'hBEEF});
      @(negedge clk);
      #1;
      check("R8", "chg_rej one cycle", {{DW+1{1'b0}}, chg_rej}, '0);
      run_pattern(2, 8'b0000_0011, 16'h6000, "R8");
   endtask

   task automatic t_reserved();
      @(negedge clk);
      lat_sel = 2'b00;
      rd_cmd = 1'b1; rd_data = 16'h7777;
      #1;
      check("R7", "cfg_err raised", {{DW+1{1'b0}}, cfg_err}, 1);
      for (int t = 0; t < 4; t++) begin
         @(negedge clk);
         rd_cmd = (t < 2);
         #1;
         check("R7", "outputs silent", {q_valid, drv_en, q_data}, '0);
      end
      @(negedge clk);
      rd_cmd = 1'b0;
      lat_sel = 2'b10;
      #1;
      check("R7", "cfg_err cleared", {{DW+1{1'b0}}, cfg_err}, '0);
      for (int t = 0; t < 4; t++) begin
         @(negedge clk);
         #1;
         check("R7", "discarded commands stay out", {q_valid, drv_en, q_data}, '0);
      end
      // latency unchanged by the reserved code: still two cycles
      run_pattern(2, 8'b0000_0001, 16'h7100, "R7");
   endtask

   task automatic t_mid_reset();
      @(negedge clk);
      rd_cmd = 1'b1; rd_data = 16'h9999;
      @(negedge clk);
      rd_cmd = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int t = 0; t < 5; t++) begin
         #1;
         check("R9", "flushed read absent", {q_valid, drv_en, q_data}, '0);
         @(negedge clk);
      end
   endtask

   initial begin
      t_reset_state();
      t_default_latency();
      t_set_latency(2'b01, 1);
      t_lat1_lead();
      t_back_to_back(1);
      t_tail(1);
      t_set_latency(2'b11, 3);
      t_back_to_back(3);
      t_tail(3);
      t_set_latency(2'b10, 2);
      t_back_to_back(2);
      t_tail(2);
      t_busy_change();
      t_reserved();
      lat_sel = 2'b11;
      t_set_latency(2'b11, 3);
      t_mid_reset();
      lat_sel = 2'b10;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule